// File: doc/BRIEF.md
# Clock Control Register Block with Strap-Derived PLL Setup

This block holds the configuration registers of a chip's clock and power controller and turns them into divider ratios for the clock generator. It keeps a PLL mode register, two control registers, an enable register and a force register, all writable through a simple register port with fixed per-register write masks. It also has three registers that cannot be written: a strap register, a constant ID register and a status register. The status register is not stored. Its value comes from the enable and force registers at every read.

While reset is held, the block samples the strap pins and builds the reset value of the PLL mode register from them one field at a time. Once reset is released the strap register keeps the sampled value and ignores the pins. Outside the block, the clock generator reads the integer ratios computed here: processor bus, feedback, forward, peripheral, external-bus and UART dividers, the overall PLL multiplier and a PLL-enable flag. All of these are combinational functions of the register contents. The register port has no handshake. A write takes effect at the rising edge where `acc_wr` is high, and read data follows `acc_addr` combinationally.

Top module: `clkctl_regs`

## Requirements
- R1: During reset, control 0 loads 0x0000003C, control 1 loads 0x2B0D8800, and the enable and force registers load zero.
- R2: A write stores the write data ANDed with a fixed mask: 0xFFF77C3F for the mode register at address 0, 0x0FFFFFFE for control 0 at address 1, 0x00800000 for control 1 at address 2, and 0xBFFC0000 for enable at address 5 and force at address 6.
- R3: Writes to address 3 (strap), address 4 (ID) and address 7 (status) change no register and no output.
- R4: A read of address 7 returns the bitwise NOT of (enable OR force), ANDed with 0xFFFF0000.
- R5: A read of address 4 always returns 0x42051049.
- R6: At reset, mode bit 31 is set unless strap bits 31:30 are 0, and strap values 1, 2 and 3 load 5, 4 and 2 into mode bits 18:16 (0 leaves them 0).
- R7: At reset, mode bits 23:20 load strap bits 29:28 plus one.
- R8: At reset, a value of 2, 4 or 5 in strap bits 27:25 places 0x13, 0x15 or 0x16 in mode bits 5:0. Any other value leaves those bits 0.
- R9: At reset, strap bits 24:23, 22:21 and 18:17 are copied to mode bits 27:26, 11:10 and 25:24. All other mode bits reset to 0.
- R10: The strap register, read at address 3, takes the strap pins on every clock edge in reset and holds that value after reset.
- R11: The bus divider is mode[27:26]+1. The feedback divider is ((mode[23:20]-1) mod 16)+1, so a field of 0 gives 16. The forward divider is 8-mode[18:16]. The peripheral divider is mode[11:10]+1, the external-bus divider is mode[25:24]+2 and the UART divider is control0[5:1]+1.
- R12: `pll_on` equals mode bit 31. `pll_mult` is bus×feedback×forward when `pll_on` is 1, and the bus divider alone when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_in | input | 32 | Strap pins, sampled during reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 3 | Register address for read and write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` |
| pll_on | output | 1 | PLL enabled (mode bit 31) |
| bus_div | output | 3 | Processor bus divider, 1 to 4 |
| fb_div | output | 5 | Feedback divider, 1 to 16 |
| fwd_div | output | 4 | Forward divider, 1 to 8 |
| periph_div | output | 3 | Peripheral bus divider, 1 to 4 |
| ext_div | output | 3 | External bus divider, 2 to 5 |
| uart_div | output | 6 | UART divider, 1 to 32 |
| pll_mult | output | 10 | PLL multiplier |

## Verification
Four things are checked by assertions on every cycle. The strap register stays frozen outside reset. Each masked write lands in the enable and control 1 registers. The ID read is constant and the low half of the status read is zero. The forward divider stays in range, and the multiplier equals the bus divider whenever the PLL is off. The field-by-field decode of the mode register from the straps can only be shown by the bench's scenarios, because each strap pattern must be applied during reset and the result compared with hand-worked constants. The same holds for the feedback wrap at a zero field and for the full set of divider values after masked writes.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned AW  = 3;
  localparam int unsigned NWR = 5;

  localparam int unsigned BUS_W  = 3;
  localparam int unsigned FB_W   = 5;
  localparam int unsigned FWD_W  = 4;
  localparam int unsigned PER_W  = 3;
  localparam int unsigned EXT_W  = 3;
  localparam int unsigned UART_W = 6;
  localparam int unsigned MULT_W = 10;

  typedef enum logic [AW-1:0] {
    SEL_MODE  = 3'd0,
    SEL_CTL0  = 3'd1,
    SEL_CTL1  = 3'd2,
    SEL_STRAP = 3'd3,
    SEL_ID    = 3'd4,
    SEL_ENA   = 3'd5,
    SEL_FRC   = 3'd6,
    SEL_STAT  = 3'd7
  } reg_sel_e;

  // writable register slots inside the register file
  localparam int unsigned W_MODE = 0;
  localparam int unsigned W_CTL0 = 1;
  localparam int unsigned W_CTL1 = 2;
  localparam int unsigned W_ENA  = 3;
  localparam int unsigned W_FRC  = 4;

  localparam logic [DW-1:0] MODE_MASK = 32'hFFF7_7C3F;
  localparam logic [DW-1:0] CTL0_MASK = 32'h0FFF_FFFE;
  localparam logic [DW-1:0] CTL1_MASK = 32'h0080_0000;
  localparam logic [DW-1:0] EF_MASK   = 32'hBFFC_0000;
  localparam logic [DW-1:0] STAT_MASK = 32'hFFFF_0000;

  localparam logic [DW-1:0] CTL0_RST  = 32'h0000_003C;
  localparam logic [DW-1:0] CTL1_RST  = 32'h2B0D_8800;
  localparam logic [DW-1:0] ID_VALUE  = 32'h4205_1049;

  typedef struct packed {
    logic              pll_on;
    logic [BUS_W-1:0]  bus;
    logic [FB_W-1:0]   fb;
    logic [FWD_W-1:0]  fwd;
    logic [PER_W-1:0]  per;
    logic [EXT_W-1:0]  ext;
    logic [UART_W-1:0] uart;
    logic [MULT_W-1:0] mult;
  } ratio_t;
endpackage

// File: rtl/clkctl_strap_decode.sv
module clkctl_strap_decode
  import clkctl_pkg::*;
(
  input  logic [DW-1:0] strap,
  output logic [DW-1:0] mode_rst
);
  logic unused_strap;
  assign unused_strap = ^{strap[20:19], strap[16:0]};

  always_comb begin
    mode_rst = '0;
    // PLL enable and forward divider select
    unique case (strap[31:30])
      2'd1: begin mode_rst[31] = 1'b1; mode_rst[18:16] = 3'd5; end
      2'd2: begin mode_rst[31] = 1'b1; mode_rst[18:16] = 3'd4; end
      2'd3: begin mode_rst[31] = 1'b1; mode_rst[18:16] = 3'd2; end
      default: ;
    endcase
    // feedback field: strap code plus one
    mode_rst[23:20] = {2'b00, strap[29:28]} + 4'd1;
    // tuning code
    unique case (strap[27:25])
      3'd2:    mode_rst[5:0] = 6'h13;
      3'd4:    mode_rst[5:0] = 6'h15;
      3'd5:    mode_rst[5:0] = 6'h16;
      default: ;
    endcase
    // direct copies
    mode_rst[27:26] = strap[24:23];
    mode_rst[11:10] = strap[22:21];
    mode_rst[25:24] = strap[18:17];
  end
endmodule

// File: rtl/clkctl_wreg.sv
module clkctl_wreg #(
  parameter int unsigned    DW   = 32,
  parameter logic [DW-1:0]  MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rst_val,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= rst_val;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] strap_in,
  input  logic [DW-1:0] mode_rst,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] ctl0_q,
  output logic [DW-1:0] ctl1_q,
  output logic [DW-1:0] ena_q,
  output logic [DW-1:0] frc_q,
  output logic [DW-1:0] strap_q
);
  localparam logic [NWR-1:0][DW-1:0] WMASK =
    {EF_MASK, EF_MASK, CTL1_MASK, CTL0_MASK, MODE_MASK};

  logic [NWR-1:0][DW-1:0] rst_vals;
  logic [NWR-1:0][DW-1:0] regs;
  logic [NWR-1:0]         hit;
  logic [DW-1:0]          status;

  assign rst_vals = {{DW{1'b0}}, {DW{1'b0}}, CTL1_RST, CTL0_RST, mode_rst};

  always_comb begin
    hit = '0;
    unique case (reg_sel_e'(acc_addr))
      SEL_MODE: hit[W_MODE] = 1'b1;
      SEL_CTL0: hit[W_CTL0] = 1'b1;
      SEL_CTL1: hit[W_CTL1] = 1'b1;
      SEL_ENA:  hit[W_ENA]  = 1'b1;
      SEL_FRC:  hit[W_FRC]  = 1'b1;
      default:  ;
    endcase
  end

  for (genvar g = 0; g < NWR; g++) begin : g_wreg
    clkctl_wreg #(.DW(DW), .MASK(WMASK[g])) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (rst_vals[g]),
      .we      (acc_wr && hit[g]),
      .wdata   (acc_wdata),
      .q       (regs[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assign mode_q = regs[W_MODE];
  assign ctl0_q = regs[W_CTL0];
  assign ctl1_q = regs[W_CTL1];
  assign ena_q  = regs[W_ENA];
  assign frc_q  = regs[W_FRC];
  assign status = ~(ena_q | frc_q) & STAT_MASK;

  always_comb begin
    unique case (reg_sel_e'(acc_addr))
      SEL_MODE:  acc_rdata = mode_q;
      SEL_CTL0:  acc_rdata = ctl0_q;
      SEL_CTL1:  acc_rdata = ctl1_q;
      SEL_STRAP: acc_rdata = strap_q;
      SEL_ID:    acc_rdata = ID_VALUE;
      SEL_ENA:   acc_rdata = ena_q;
      SEL_FRC:   acc_rdata = frc_q;
      default:   acc_rdata = status;
    endcase
  end
endmodule

// File: rtl/clkctl_ratio.sv
module clkctl_ratio
  import clkctl_pkg::*;
(
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] ctl0,
  output ratio_t        ratio
);
  logic [3:0] fb_m1;
  logic unused_bits;
  assign unused_bits = ^{mode[30:28], mode[19], mode[15:12], mode[9:0],
                         ctl0[31:6], ctl0[0]};

  assign fb_m1 = mode[23:20] - 4'd1;

  always_comb begin
    ratio.pll_on = mode[31];
    ratio.bus    = {1'b0, mode[27:26]} + 3'd1;
    ratio.fb     = {1'b0, fb_m1} + 5'd1;
    ratio.fwd    = 4'd8 - {1'b0, mode[18:16]};
    ratio.per    = {1'b0, mode[11:10]} + 3'd1;
    ratio.ext    = {1'b0, mode[25:24]} + 3'd2;
    ratio.uart   = {1'b0, ctl0[5:1]} + 6'd1;
    if (mode[31])
      ratio.mult = MULT_W'(ratio.bus) * MULT_W'(ratio.fb) * MULT_W'(ratio.fwd);
    else
      ratio.mult = MULT_W'(ratio.bus);
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     strap_in,
  input  logic              acc_wr,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  output logic              pll_on,
  output logic [BUS_W-1:0]  bus_div,
  output logic [FB_W-1:0]   fb_div,
  output logic [FWD_W-1:0]  fwd_div,
  output logic [PER_W-1:0]  periph_div,
  output logic [EXT_W-1:0]  ext_div,
  output logic [UART_W-1:0] uart_div,
  output logic [MULT_W-1:0] pll_mult
);
  logic [DW-1:0] mode_rst, mode_q, ctl0_q, ctl1_q, ena_q, frc_q, strap_q;
  ratio_t        ratio;

  clkctl_strap_decode u_dec (.strap(strap_in), .mode_rst(mode_rst));

  clkctl_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_in  (strap_in),
    .mode_rst  (mode_rst),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .mode_q    (mode_q),
    .ctl0_q    (ctl0_q),
    .ctl1_q    (ctl1_q),
    .ena_q     (ena_q),
    .frc_q     (frc_q),
    .strap_q   (strap_q)
  );

  clkctl_ratio u_ratio (.mode(mode_q), .ctl0(ctl0_q), .ratio(ratio));

  assign pll_on     = ratio.pll_on;
  assign bus_div    = ratio.bus;
  assign fb_div     = ratio.fb;
  assign fwd_div    = ratio.fwd;
  assign periph_div = ratio.per;
  assign ext_div    = ratio.ext;
  assign uart_div   = ratio.uart;
  assign pll_mult   = ratio.mult;
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk
  import clkctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_wr,
  input logic [AW-1:0]     acc_addr,
  input logic [DW-1:0]     acc_wdata,
  input logic [DW-1:0]     acc_rdata,
  input logic [DW-1:0]     strap_q,
  input logic [DW-1:0]     ctl1_q,
  input logic [DW-1:0]     ena_q,
  input logic              pll_on,
  input logic [BUS_W-1:0]  bus_div,
  input logic [FWD_W-1:0]  fwd_div,
  input logic [MULT_W-1:0] pll_mult
);
  assert_strap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n)) |-> $stable(strap_q));

  assert_strap_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == 3'(SEL_STRAP)) |=> $stable(strap_q));

  assert_ctl1_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == 3'(SEL_CTL1)) |=> ctl1_q == ($past(acc_wdata) & CTL1_MASK));

  assert_ena_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_addr == 3'(SEL_ENA)) |=> ena_q == ($past(acc_wdata) & EF_MASK));

  assert_id_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 3'(SEL_ID)) |-> acc_rdata == ID_VALUE);

  assert_status_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 3'(SEL_STAT)) |-> acc_rdata[15:0] == 16'h0000);

  assert_fwd_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_div != '0 && fwd_div <= 4'd8);

  assert_bypass_mult_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |-> pll_mult == MULT_W'(bus_div));
endmodule

bind clkctl_regs clkctl_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .strap_q   (strap_q),
  .ctl1_q    (ctl1_q),
  .ena_q     (ena_q),
  .pll_on    (pll_on),
  .bus_div   (bus_div),
  .fwd_div   (fwd_div),
  .pll_mult  (pll_mult)
);

// File: tb/clkctl_regs_test.sv
module clkctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_in = 32'h0;
  logic        acc_wr = 1'b0;
  logic [2:0]  acc_addr = 3'd0;
  logic [31:0] acc_wdata = 32'h0;
  logic [31:0] acc_rdata;
  logic        pll_on;
  logic [2:0]  bus_div, periph_div, ext_div;
  logic [4:0]  fb_div;
  logic [3:0]  fwd_div;
  logic [5:0]  uart_div;
  logic [9:0]  pll_mult;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkctl_regs uut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pll_on(pll_on), .bus_div(bus_div), .fb_div(fb_div), .fwd_div(fwd_div),
    .periph_div(periph_div), .ext_div(ext_div), .uart_div(uart_div),
    .pll_mult(pll_mult)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_mode, m_ctl0, m_ctl1, m_ena, m_frc, m_strap;
  bit m_valid = 1'b0;

  function automatic logic [31:0] ref_decode(input logic [31:0] s);
    int fwd_code, fbc, pt;
    logic [31:0] r;
    fwd_code = int'(s >> 30) & 3;
    fbc      = int'(s >> 28) & 3;
    pt       = int'(s >> 25) & 7;
    r = 32'(fbc + 1) << 20;
    if (fwd_code == 1) r = r | 32'h8005_0000;
    if (fwd_code == 2) r = r | 32'h8004_0000;
    if (fwd_code == 3) r = r | 32'h8002_0000;
    if (pt == 2) r = r | 32'h13;
    if (pt == 4) r = r | 32'h15;
    if (pt == 5) r = r | 32'h16;
    r = r | (((s >> 23) & 32'h3) << 26);
    r = r | (((s >> 21) & 32'h3) << 10);
    r = r | (((s >> 17) & 32'h3) << 24);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_strap <= strap_in;
      m_mode  <= ref_decode(strap_in);
      m_ctl0  <= 32'h0000_003C;
      m_ctl1  <= 32'h2B0D_8800;
      m_ena   <= 32'h0;
      m_frc   <= 32'h0;
      m_valid <= 1'b1;
    end else if (acc_wr) begin
      case (acc_addr)
        3'd0: m_mode <= acc_wdata & 32'hFFF7_7C3F;
        3'd1: m_ctl0 <= acc_wdata & 32'h0FFF_FFFE;
        3'd2: m_ctl1 <= acc_wdata & 32'h0080_0000;
        3'd5: m_ena  <= acc_wdata & 32'hBFFC_0000;
        3'd6: m_frc  <= acc_wdata & 32'hBFFC_0000;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_ctl0;
      3'd2: return m_ctl1;
      3'd3: return m_strap;
      3'd4: return 32'h4205_1049;
      3'd5: return m_ena;
      3'd6: return m_frc;
      default: return ~(m_ena | m_frc) & 32'hFFFF_0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_valid && !done) begin
      int bus, fb, fwd, mult;
      bus  = ((int'(m_mode) >>> 26) & 3) + 1;
      fb   = (((int'(m_mode >> 20) & 15) + 15) % 16) + 1;
      fwd  = 8 - (int'(m_mode >> 16) & 7);
      mult = m_mode[31] ? bus * fb * fwd : bus;
      check("R2/R3/R4/R5 model read", acc_rdata, ref_read(acc_addr));
      check("R12 model pll_on", 32'(pll_on), 32'(m_mode[31]));
      check("R11 model bus", 32'(bus_div), 32'(bus));
      check("R11 model fb", 32'(fb_div), 32'(fb));
      check("R11 model fwd", 32'(fwd_div), 32'(fwd));
      check("R11 model periph", 32'(periph_div), 32'((int'(m_mode >> 10) & 3) + 1));
      check("R11 model ext", 32'(ext_div), 32'((int'(m_mode >> 24) & 3) + 2));
      check("R11 model uart", 32'(uart_div), 32'((int'(m_ctl0 >> 1) & 31) + 1));
      check("R12 model mult", 32'(pll_mult), 32'(mult));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic [31:0] s);
    acc_wr = 1'b0;
    rst_n = 1'b0;
    strap_in = s;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    step();
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    acc_addr = a;
    @(negedge clk);
    check(tag, acc_rdata, exp);
    #1;
  endtask

  task automatic sweep();
    for (int i = 0; i < 8; i++) begin
      acc_addr = 3'(i);
      step();
    end
  endtask

  task automatic chk_div(input int b, input int f, input int w, input int m, input string tag);
    @(negedge clk);
    check({tag, " R11 bus"}, 32'(bus_div), 32'(b));
    check({tag, " R11 fb"}, 32'(fb_div), 32'(f));
    check({tag, " R11 fwd"}, 32'(fwd_div), 32'(w));
    check({tag, " R12 mult"}, 32'(pll_mult), 32'(m));
    #1;
  endtask

  initial begin
    step();
    // typical strap pattern
    do_reset(32'h9AA4_0000);
    rd(3'd1, 32'h0000_003C, "R1 ctl0 reset");
    rd(3'd2, 32'h2B0D_8800, "R1 ctl1 reset");
    rd(3'd5, 32'h0, "R1 enable reset");
    rd(3'd6, 32'h0, "R1 force reset");
    rd(3'd0, 32'h8624_0416, "R6 R7 R8 R9 mode from straps");
    chk_div(2, 2, 4, 16, "strap A");
    @(negedge clk);
    check("R11 periph", 32'(periph_div), 32'd2);
    check("R11 ext", 32'(ext_div), 32'd4);
    check("R11 uart", 32'(uart_div), 32'd31);
    #1;
    rd(3'd4, 32'h4205_1049, "R5 id");
    rd(3'd7, 32'hFFFF_0000, "R4 status after reset");
    // strap pins move after reset
    strap_in = 32'h1234_5678;
    step(); step();
    rd(3'd3, 32'h9AA4_0000, "R10 strap held");
    sweep();

    // bypass straps
    do_reset(32'h0000_0000);
    rd(3'd0, 32'h0010_0000, "R6 R7 mode bypass");
    chk_div(1, 1, 8, 1, "bypass R12");
    // all-ones straps
    do_reset(32'hFFFF_FFFF);
    rd(3'd0, 32'h8F42_0C00, "R6 R8 R9 mode ones");
    rd(3'd3, 32'hFFFF_FFFF, "R10 strap sampled");
    chk_div(4, 4, 6, 96, "ones");
    // tuning codes 2 and 4
    do_reset(32'h4400_0000);
    rd(3'd0, 32'h8015_0013, "R8 tuning code 2");
    chk_div(1, 1, 3, 3, "code2");
    do_reset(32'h4800_0000);
    rd(3'd0, 32'h8015_0015, "R8 tuning code 4");
    sweep();

    // masked writes
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'hFFF7_7C3F, "R2 mode mask");
    chk_div(4, 15, 1, 60, "mode ones");
    @(negedge clk);
    check("R11 periph max", 32'(periph_div), 32'd4);
    check("R11 ext max", 32'(ext_div), 32'd5);
    #1;
    wr(3'd0, 32'h8000_0000);
    chk_div(1, 16, 8, 128, "R11 fb wrap");
    wr(3'd0, 32'h0000_0000);
    chk_div(1, 16, 8, 1, "R12 bypass after write");
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h0FFF_FFFE, "R2 ctl0 mask");
    @(negedge clk);
    check("R11 uart max", 32'(uart_div), 32'd32);
    #1;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'h0080_0000, "R2 ctl1 mask");
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, 32'hBFFC_0000, "R2 enable mask");
    rd(3'd7, 32'h4003_0000, "R4 status with enable");
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h4003_FFFF);
    rd(3'd6, 32'h0000_0000, "R2 force mask drops bits");
    wr(3'd6, 32'h8004_0000);
    rd(3'd7, 32'h7FFB_0000, "R4 status with force");
    sweep();

    // read-only addresses
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, 32'hFFFF_FFFF & 32'h4800_0000, "R3 strap write ignored");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'h4205_1049, "R3 id write ignored");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, 32'h7FFB_0000, "R3 status write ignored");
    rd(3'd0, 32'h0000_0000, "R3 mode untouched");
    sweep();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      done = 1'b1;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule